// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block bridges a synchronous, single-beat request port to an asynchronous 128K x 8 static RAM. The host presents a read/write flag, a 17-bit address and write data with a valid signal. The controller takes the request when valid and ready are both high. It then runs the RAM cycle on the memory pins and holds ready low until the cycle and its recovery are over. Read data returns with a one-cycle valid pulse.

The RAM is selected only when its low-active select is low and its high-active select is high. Writes occur while write enable is low and output enable is high. Reads occur while output enable is low. The data bus appears as separate out, in and drive-enable signals. Every timing minimum (access, write pulse, data setup, recovery, bus turnaround, bus release) is a nanosecond parameter. Each one is converted to whole clock cycles, rounded up, at the given clock period. A build-time mode selects which strobe ends a write: write enable, the low-active select or the high-active select.

Top module: `asram_bridge`

## Requirements
- R1: After reset and whenever the controller is idle, ready is high, the low-active select is 1, the high-active select is 0, write enable and output enable are 1 (inactive), and the data drive-enable is 0.
- R2: Each timing parameter in nanoseconds becomes ceil(ns*1000/CLK_PS) clock cycles. With the defaults at a 4 ns clock this gives access 3, pulse 4, data setup 2, recovery 2, turnaround 1 and release 2.
- R3: A read holds both selects active, output enable low and write enable high for the access count. It samples the bus at the end of that window. rspValid is high for exactly one cycle, the (access+1)-th cycle after acceptance, carrying the sampled byte.
- R4: After a read's sampling edge, all strobes are inactive for the release count before ready returns. Ready is therefore high again in the (access+release+1)-th cycle after acceptance.
- R5: A write keeps all three write-qualifying strobes asserted for PW = max(pulse, turnaround+setup) cycles. Write enable and output enable are never low together.
- R6: WRITE_MODE 0, 1 and 2 make write enable, the low-active select or the high-active select respectively the only strobe that ends the write. The other strobes stay asserted for one more cycle.
- R7: Data drivers are on only while a write is active and output enable is high, and only after output enable has been high for the turnaround count. They turn off on the edge that ends the write. The driven data is stable for at least the setup count before that edge.
- R8: After a write ends, the address is held and ready stays low for max(recovery,1) cycles, so ready is high in the (PW+recovery+1)-th cycle after acceptance.
- R9: A request is taken only on a cycle with valid and ready both high. While busy, a pending valid request with changed fields has no effect on the memory pins.
- R10: A byte written to an address is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle read data valid |
| rspRdata | output | DATA_W | Read data |
| memAddr | output | ADDR_W | RAM address |
| memDout | output | DATA_W | Data toward the RAM |
| memDin | input | DATA_W | Data from the RAM |
| memDoe | output | 1 | Data drive-enable toward the RAM |
| memSelN | output | 1 | Low-active chip select |
| memSel | output | 1 | High-active chip select |
| memWeN | output | 1 | Low-active write enable |
| memOeN | output | 1 | Low-active output enable |

## Verification
Two events share one clock edge: the terminating strobe leaving its active level and the data drivers switching off. If the drive-enable lasts one cycle too long, or a second strobe moves on the same edge, the memory sees a corrupted or mistimed write end. The bench runs three controllers side by side, one per write mode, each attached to a RAM model. Every model records which strobe ended each write, how long the pulse lasted, how long the data was stable, and any cycle where drivers were on outside a write. The bench compares these records against the mode and the cycle counts after every write.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WPULSE, ST_WREC, ST_RACC, ST_RREL
  } ctlState_t;

  // strobes from control to datapath, all active high
  typedef struct packed {
    logic load;
    logic selNOn;
    logic selOn;
    logic weOn;
    logic oeOn;
    logic drive;
    logic capture;
  } strobe_t;

  function automatic int cycCeil(input int ns, input int clkPs);
    return (ns * 1000 + clkPs - 1) / clkPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int PW   = 4,
  parameter int RC   = 2,
  parameter int ACC  = 3,
  parameter int REL  = 2,
  parameter int TURN = 1,
  parameter int MODE = 0,
  parameter int CW   = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    rspValid,
  output strobe_t strb
);

  localparam logic [CW-1:0] PW_END  = CW'(PW - 1);
  localparam logic [CW-1:0] RC_END  = CW'(RC - 1);
  localparam logic [CW-1:0] ACC_END = CW'(ACC - 1);
  localparam logic [CW-1:0] REL_END = CW'(REL - 1);
  // strobes that stay asserted for the first recovery cycle
  localparam bit KEEP_WE   = (MODE != 0);
  localparam bit KEEP_SELN = (MODE != 1);
  localparam bit KEEP_SEL  = (MODE != 2);

  ctlState_t state;
  logic [CW-1:0] cnt;

  always_comb begin
    strb     = '0;
    reqReady = (state == ST_IDLE);
    case (state)
      ST_IDLE:   strb.load = reqValid;
      ST_WPULSE: begin
        strb.selNOn = 1'b1;
        strb.selOn  = 1'b1;
        strb.weOn   = 1'b1;
        strb.drive  = (int'(cnt) >= TURN);
      end
      ST_WREC: begin
        strb.selNOn = KEEP_SELN && (cnt == '0);
        strb.selOn  = KEEP_SEL  && (cnt == '0);
        strb.weOn   = KEEP_WE   && (cnt == '0);
      end
      ST_RACC: begin
        strb.selNOn  = 1'b1;
        strb.selOn   = 1'b1;
        strb.oeOn    = 1'b1;
        strb.capture = (cnt == ACC_END);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= strb.capture;
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= reqWrite ? ST_WPULSE : ST_RACC;
          cnt   <= '0;
        end
        ST_WPULSE: if (cnt == PW_END) begin
          state <= ST_WREC;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_WREC: if (cnt == RC_END) state <= ST_IDLE;
                 else cnt <= cnt + 1'b1;
        ST_RACC: if (cnt == ACC_END) begin
          state <= ST_RREL;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_RREL: if (cnt == REL_END) state <= ST_IDLE;
                 else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic              memSelN,
  output logic              memSel,
  output logic              memWeN,
  output logic              memOeN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= memDin;
    end
  end

  assign memAddr  = addrQ;
  assign memDout  = wdataQ;
  assign memDoe   = strb.drive;
  assign memSelN  = ~strb.selNOn;
  assign memSel   = strb.selOn;
  assign memWeN   = ~strb.weOn;
  assign memOeN   = ~strb.oeOn;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int WRITE_MODE = 0,
  parameter int CLK_PS     = 4000,
  parameter int T_ACC_NS   = 12,
  parameter int T_WP_NS    = 13,
  parameter int T_DS_NS    = 8,
  parameter int T_REC_NS   = 5,
  parameter int T_TURN_NS  = 4,
  parameter int T_REL_NS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDoe,
  output logic              memSelN,
  output logic              memSel,
  output logic              memWeN,
  output logic              memOeN
);

  localparam int ACC_C  = maxOf(cycCeil(T_ACC_NS, CLK_PS), 1);
  localparam int WP_C   = maxOf(cycCeil(T_WP_NS, CLK_PS), 1);
  localparam int DS_C   = maxOf(cycCeil(T_DS_NS, CLK_PS), 1);
  localparam int TURN_C = cycCeil(T_TURN_NS, CLK_PS);
  localparam int RC_C   = maxOf(cycCeil(T_REC_NS, CLK_PS), 1);
  localparam int REL_C  = maxOf(cycCeil(T_REL_NS, CLK_PS), 1);
  localparam int PW_C   = maxOf(WP_C, TURN_C + DS_C);
  localparam int MAX_C  = maxOf(maxOf(PW_C, RC_C), maxOf(ACC_C, REL_C));
  localparam int CW     = $clog2(MAX_C + 1);

  strobe_t strb;

  asram_ctrl #(
    .PW(PW_C), .RC(RC_C), .ACC(ACC_C), .REL(REL_C),
    .TURN(TURN_C), .MODE(WRITE_MODE), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .rspValid(rspValid), .strb(strb)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDin(memDin), .rspRdata(rspRdata),
    .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
    .memSelN(memSelN), .memSel(memSel), .memWeN(memWeN), .memOeN(memOeN)
  );

endmodule

// File: rtl/asram_bridge_chk.sv
module asram_bridge_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int TURN   = 1,
  parameter int DS     = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout,
  input logic              memDoe,
  input logic              memSelN,
  input logic              memSel,
  input logic              memWeN,
  input logic              memOeN
);

  logic       writeAct;
  logic       prevAct;
  logic [7:0] oeHighCnt;
  logic [7:0] doeCnt;

  assign writeAct = !memSelN && memSel && !memWeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAct   <= 1'b0;
      oeHighCnt <= '0;
      doeCnt    <= '0;
    end else begin
      prevAct   <= writeAct;
      oeHighCnt <= !memOeN ? 8'd0 : (oeHighCnt == 8'hFF ? oeHighCnt : oeHighCnt + 8'd1);
      doeCnt    <= !memDoe ? 8'd0 : (doeCnt == 8'hFF ? doeCnt : doeCnt + 8'd1);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memSelN && !memSel && memWeN && memOeN && !memDoe));

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_no_we_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  p_drive_in_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> (writeAct && memOeN));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> (int'(oeHighCnt) >= TURN));

  p_data_setup_r7: assert property (@(posedge clk) disable iff (!rstN)
    (prevAct && !writeAct) |-> (int'(doeCnt) >= DS && !memDoe));

  p_data_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memDoe && $past(memDoe)) |-> $stable(memDout));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(memAddr));

endmodule

bind asram_bridge asram_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN(TURN_C), .DS(DS_C)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
  .memSelN(memSelN), .memSel(memSel), .memWeN(memWeN), .memOeN(memOeN)
);

// File: tb/asram_ram_model.sv
module asram_ram_model #(
  parameter int ACC = 3
) (
  input  logic        clk,
  input  logic [16:0] memAddr,
  input  logic [7:0]  memDout,
  input  logic        memDoe,
  input  logic        memSelN,
  input  logic        memSel,
  input  logic        memWeN,
  input  logic        memOeN,
  output logic [7:0]  memDin,
  output int          commits,
  output int          lastPw,
  output int          lastDs,
  output int          lastTerm,
  output int          viol
);

  logic [7:0] mem [0:255];
  logic       wrAct, rdAct;
  int         accCnt, pwCnt, dsCnt, nChg;
  logic       pAct, pWeN, pSelN, pSel;
  logic [7:0] lastD, pAddr;

  assign wrAct  = !memSelN && memSel && !memWeN;
  assign rdAct  = !memSelN && memSel && memWeN && !memOeN;
  assign memDin = (rdAct && accCnt >= ACC) ? mem[memAddr[7:0]] : 8'hEE;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    commits = 0; lastPw = 0; lastDs = 0; lastTerm = -1; viol = 0;
    accCnt = 0; pwCnt = 0; dsCnt = 0; nChg = 0;
    pAct = 1'b0; pWeN = 1'b1; pSelN = 1'b1; pSel = 1'b0;
    lastD = 8'h00; pAddr = 8'h00;
  end

  always @(negedge clk) begin
    if (memDoe && !(wrAct && memOeN)) viol = viol + 1;
    accCnt = rdAct ? accCnt + 1 : 0;
    if (wrAct) begin
      pwCnt = pwCnt + 1;
      if (memDoe) begin
        dsCnt = (dsCnt > 0 && memDout != lastD) ? 1 : dsCnt + 1;
        lastD = memDout;
      end else dsCnt = 0;
    end else if (pAct) begin
      mem[pAddr] = lastD;
      commits = commits + 1;
      lastPw  = pwCnt;
      lastDs  = dsCnt;
      nChg = int'(memWeN != pWeN) + int'(memSelN != pSelN) + int'(memSel != pSel);
      if (nChg != 1) lastTerm = 3;
      else if (memWeN && !pWeN) lastTerm = 0;
      else if (memSelN && !pSelN) lastTerm = 1;
      else lastTerm = 2;
      pwCnt = 0;
      dsCnt = 0;
    end
    pAct  = wrAct;
    pWeN  = memWeN;
    pSelN = memSelN;
    pSel  = memSel;
    pAddr = memAddr[7:0];
  end

endmodule

// File: tb/asram_bridge_tb.sv
`timescale 1ns/1ps
module asram_bridge_tb;

  // expected cycle counts at a 4 ns clock (R2)
  localparam int ACC = 3, PW = 4, DS = 2, TURN = 1, RC = 2, REL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;

  logic        ready [3];
  logic        rspV  [3];
  logic [7:0]  rspD  [3];
  logic [16:0] mAddr [3];
  logic [7:0]  mDout [3];
  logic [7:0]  mDin  [3];
  logic        mDoe  [3];
  logic        mSelN [3];
  logic        mSel  [3];
  logic        mWeN  [3];
  logic        mOeN  [3];
  int commits [3];
  int lastPw  [3];
  int lastDs  [3];
  int lastTerm[3];
  int viol    [3];

  asram_bridge #(.WRITE_MODE(0)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(ready[0]),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspV[0]), .rspRdata(rspD[0]), .memAddr(mAddr[0]),
    .memDout(mDout[0]), .memDin(mDin[0]), .memDoe(mDoe[0]),
    .memSelN(mSelN[0]), .memSel(mSel[0]), .memWeN(mWeN[0]), .memOeN(mOeN[0]));

  asram_bridge #(.WRITE_MODE(1)) u_dut1 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(ready[1]),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspV[1]), .rspRdata(rspD[1]), .memAddr(mAddr[1]),
    .memDout(mDout[1]), .memDin(mDin[1]), .memDoe(mDoe[1]),
    .memSelN(mSelN[1]), .memSel(mSel[1]), .memWeN(mWeN[1]), .memOeN(mOeN[1]));

  asram_bridge #(.WRITE_MODE(2)) u_dut2 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(ready[2]),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspV[2]), .rspRdata(rspD[2]), .memAddr(mAddr[2]),
    .memDout(mDout[2]), .memDin(mDin[2]), .memDoe(mDoe[2]),
    .memSelN(mSelN[2]), .memSel(mSel[2]), .memWeN(mWeN[2]), .memOeN(mOeN[2]));

  for (genvar g = 0; g < 3; g++) begin : g_ram
    asram_ram_model #(.ACC(ACC)) u_ram (
      .clk(clk), .memAddr(mAddr[g]), .memDout(mDout[g]), .memDoe(mDoe[g]),
      .memSelN(mSelN[g]), .memSel(mSel[g]), .memWeN(mWeN[g]), .memOeN(mOeN[g]),
      .memDin(mDin[g]), .commits(commits[g]), .lastPw(lastPw[g]),
      .lastDs(lastDs[g]), .lastTerm(lastTerm[g]), .viol(viol[g]));
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk(ready[d] === 1'b1, "R1 ready", int'(ready[d]), 1);
      chk({mSelN[d], mSel[d], mWeN[d], mOeN[d], mDoe[d]} === 5'b10110, "R1 idle strobes",
          int'({mSelN[d], mSel[d], mWeN[d], mOeN[d], mDoe[d]}), 5'b10110);
    end
  endtask

  // one write; R2 R5 R6 R7 R8 R9
  task automatic do_write(input logic [16:0] a, input logic [7:0] dt);
    int n, c0[3];
    for (int d = 0; d < 3; d++) c0[d] = commits[d];
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = dt;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~dt;
    n = 1;
    while (!ready[0] && n < 100) begin @(negedge clk); n++; end
    chk(n == PW + RC + 1, "R8 write busy cycles (R2 rounding)", n, PW + RC + 1);
    for (int d = 0; d < 3; d++) begin
      chk(ready[d] === ready[0], "R9 ready match", int'(ready[d]), int'(ready[0]));
      chk(commits[d] == c0[d] + 1, "R9 one write", commits[d], c0[d] + 1);
      chk(lastPw[d] == PW, "R5 pulse cycles", lastPw[d], PW);
      chk(lastDs[d] == PW - TURN && lastDs[d] >= DS, "R7 data setup", lastDs[d], PW - TURN);
      chk(lastTerm[d] == d, "R6 ending strobe", lastTerm[d], d);
      chk(viol[d] == 0, "R7 drive outside write", viol[d], 0);
    end
  endtask

  // one read; R3 R4 R10
  task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
    int n;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a;
    n = 1;
    chk({mSelN[0], mSel[0], mWeN[0], mOeN[0], mDoe[0]} === 5'b01100, "R3 read strobes",
        int'({mSelN[0], mSel[0], mWeN[0], mOeN[0], mDoe[0]}), 5'b01100);
    while (!rspV[0] && n < 100) begin @(negedge clk); n++; end
    chk(n == ACC + 1, "R3 read latency", n, ACC + 1);
    for (int d = 0; d < 3; d++)
      chk(rspV[d] && rspD[d] == exp, "R10 read data", int'(rspD[d]), int'(exp));
    @(negedge clk); n++;
    chk(rspV[0] === 1'b0, "R3 valid one cycle", int'(rspV[0]), 0);
    chk({mSelN[0], mSel[0], mOeN[0]} === 3'b101, "R4 released", int'({mSelN[0], mSel[0], mOeN[0]}), 3'b101);
    while (!ready[0] && n < 100) begin @(negedge clk); n++; end
    chk(n == ACC + REL + 1, "R4 ready after release", n, ACC + REL + 1);
  endtask

  // valid held high with changing fields while busy; R9
  task automatic test_held_valid();
    int n, c0;
    c0 = commits[0];
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h00030; reqWdata = 8'h3C;
    @(negedge clk);
    reqAddr = 17'h00031; reqWdata = 8'hC3;
    n = 1;
    while (!ready[0] && n < 100) begin
      chk(mAddr[0] == 17'h00030, "R9 address held while busy", int'(mAddr[0]), 'h30);
      @(negedge clk); n++;
    end
    chk(commits[0] == c0 + 1, "R9 only first write done", commits[0], c0 + 1);
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (!ready[0] && n < 100) begin @(negedge clk); n++; end
    chk(commits[0] == c0 + 2, "R9 second write after ready", commits[0], c0 + 2);
    do_read(17'h00030, 8'h3C);
    do_read(17'h00031, 8'hC3);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    do_write(17'h00005, 8'hA5);
    do_read(17'h00005, 8'hA5);
    do_write(17'h1FFFF, 8'hFF);
    do_write(17'h00000, 8'h01);
    do_read(17'h1FFFF, 8'hFF);
    do_read(17'h00000, 8'h01);
    do_write(17'h00005, 8'h5A);
    do_read(17'h00005, 8'h5A);
    test_held_valid();
    test_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule